// File: doc/BRIEF.md
# First-Word-Fall-Through FIFO Buffer

This block is a single-clock queue that always shows its oldest unconsumed word on the read data port. No read request is needed to fetch a word. A consumer checks the valid flag, uses the word that is already on the bus, and pulses the read request to acknowledge it. On the next clock edge the following word moves onto the bus. A producer writes with a one-cycle enable whenever the full flag is low, or in the same cycle as an accepted read.

Depth and data width are parameters. Storage is a plain register array with a combinational read port. Separate write and read pointers wrap at the configured depth, and a separate occupancy counter drives the flags. Reset is synchronous and active high.

Top module: `fwft_queue`

## Requirements
- R1: When `srst` is high at a rising clock edge, the queue becomes empty: after that edge `avail` is 0 and `full` is 0, and all stored words are discarded.
- R2: A word written into an empty queue is on `pop_data` with `avail` high right after the write edge, without any `pop` pulse.
- R3: When `avail` is high and `pop` is low, `pop_data` keeps its value into the next cycle. When `avail` and `pop` are both high, the head word is consumed, and the next stored word (if any) is on `pop_data` right after that edge. This allows a `pop` in every cycle.
- R4: Words leave in exactly the order they were accepted.
- R5: A `pop` while `avail` is 0 is ignored. The queue stays empty, and the next written word becomes the head.
- R6: A `push` while `full` is 1 and `pop` is 0 is ignored. `full` stays high, and the stored words and their order are unchanged.
- R7: With `full` high, a `push` together with `pop` is accepted. The head is consumed, the new word is appended at the tail, and `full` stays high.
- R8: With `avail` low, a `push` together with `pop` stores the new word, and that word is shown on `pop_data` with `avail` high after the edge. The `pop` is ignored.
- R9: `full` is high exactly when DEPTH words are held. `avail` is high exactly when at least one word is held. Occupancy changes by at most one per cycle.
- R10: On a partly filled queue, a simultaneous `push` and `pop` leaves the occupancy unchanged, so neither flag changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| srst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Write request |
| push_data | input | DATA_W | Word to write |
| pop | input | 1 | Acknowledge and consume the displayed word |
| pop_data | output | DATA_W | Oldest unconsumed word |
| avail | output | 1 | High when pop_data holds a valid word (not empty) |
| full | output | 1 | High when DEPTH words are held |

## Verification
The bound checker tests these properties on every cycle:
- reset clearing the flags;
- a write into an empty queue raising `avail` on the next edge;
- the head holding steady while it is not acknowledged;
- writes refused at full, and the swap case at full;
- ignored reads on an empty queue;
- occupancy moving by at most one word per cycle.

Data ordering, the exact word that falls through after each acknowledge, and the integrity of stored words after refused writes are shown only by the bench's scoreboard scenarios. These scenarios fill, overfill, swap at full, drain back to back, read from empty, and interleave traffic.

// File: rtl/fwft_pkg.sv
package fwft_pkg;

  // Advance a circular index, wrapping at the configured depth.
  function automatic int unsigned ptr_step(input int unsigned p, input int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  // Next occupancy from the accepted write and read of this cycle.
  function automatic int unsigned level_step(input int unsigned lvl, input bit inc, input bit dec);
    int unsigned r;
    r = lvl;
    if (inc && !dec) r = lvl + 1;
    if (dec && !inc) r = lvl - 1;
    return r;
  endfunction

endpackage

// File: rtl/fwft_ptr.sv
module fwft_ptr #(
  parameter int DEPTH = 8,
  parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr
);
  import fwft_pkg::*;

  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (srst)     ptr_q <= '0;
    else if (adv) ptr_q <= PTR_W'(ptr_step(int'(ptr_q), DEPTH));
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/fwft_store.sv
module fwft_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] row [DEPTH];

  // One register row per entry, each with its own write decode.
  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    always_ff @(posedge clk) begin
      if (we && (waddr == PTR_W'(i))) row[i] <= wdata;
    end
  end

  // Combinational read: the head row is always visible.
  assign rdata = row[raddr];
endmodule

// File: rtl/fwft_level.sv
module fwft_level #(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] level,
  output logic             avail,
  output logic             full
);
  import fwft_pkg::*;

  logic [CNT_W-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (srst) lvl_q <= '0;
    else      lvl_q <= CNT_W'(level_step(int'(lvl_q), inc, dec));
  end

  assign level = lvl_q;
  assign avail = (lvl_q != '0);
  assign full  = (lvl_q == CNT_W'(DEPTH));
endmodule

// File: rtl/fwft_queue.sv
module fwft_queue #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              srst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic              avail,
  output logic              full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [CNT_W-1:0] level;

  // Named internal events, visible to the bound checker.
  logic rd_ok;  // a displayed word is acknowledged this cycle
  logic wr_ok;  // a write is accepted this cycle

  assign rd_ok = pop & avail;
  assign wr_ok = push & (~full | rd_ok);

  fwft_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_wptr (
    .clk(clk), .srst(srst), .adv(wr_ok), .ptr(wr_ptr)
  );

  fwft_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_rptr (
    .clk(clk), .srst(srst), .adv(rd_ok), .ptr(rd_ptr)
  );

  fwft_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk(clk), .we(wr_ok), .waddr(wr_ptr), .wdata(push_data),
    .raddr(rd_ptr), .rdata(pop_data)
  );

  fwft_level #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_level (
    .clk(clk), .srst(srst), .inc(wr_ok), .dec(rd_ok),
    .level(level), .avail(avail), .full(full)
  );
endmodule

// File: rtl/fwft_queue_chk.sv
module fwft_queue_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              srst,
  input logic              push,
  input logic              pop,
  input logic [DATA_W-1:0] pop_data,
  input logic              avail,
  input logic              full,
  input logic [CNT_W-1:0]  level,
  input logic              wr_ok,
  input logic              rd_ok
);
  AST_RESET_CLEARS: assert property (@(posedge clk) srst |=> (!avail && !full)); // R1
  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (srst)
    (!avail && push) |=> avail); // R2
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (srst)
    (avail && !pop) |=> (avail && $stable(pop_data))); // R3
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (srst)
    (!avail && pop && !push) |=> (!avail && !$past(rd_ok))); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (srst)
    (full && push && !pop) |=> (full && $stable(pop_data) && !$past(wr_ok))); // R6
  AST_FULL_SWAP: assert property (@(posedge clk) disable iff (srst)
    (full && push && pop) |=> full); // R7
  AST_FLAG_SANE: assert property (@(posedge clk) disable iff (srst)
    !(full && !avail)); // R9
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (srst)
    1'b1 |=> ((level == $past(level)) || (level == $past(level) + CNT_W'(1))
              || (level + CNT_W'(1) == $past(level)))); // R9
  AST_SWAP_LEVEL: assert property (@(posedge clk) disable iff (srst)
    (avail && push && pop) |=> $stable(level)); // R10
endmodule

bind fwft_queue fwft_queue_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .srst(srst), .push(push), .pop(pop), .pop_data(pop_data),
  .avail(avail), .full(full), .level(level), .wr_ok(wr_ok), .rd_ok(rd_ok)
);

// File: tb/sim_fwft_queue.sv
module sim_fwft_queue;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 8;

  logic              clk = 1'b0;
  logic              srst = 1'b1;
  logic              push = 1'b0;
  logic [DATA_W-1:0] push_data = '0;
  logic              pop = 1'b0;
  logic [DATA_W-1:0] pop_data;
  logic              avail;
  logic              full;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [DATA_W-1:0] sb [$];   // scoreboard of expected words, oldest first

  always #5 clk = ~clk;

  fwft_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .srst(srst), .push(push), .push_data(push_data),
    .pop(pop), .pop_data(pop_data), .avail(avail), .full(full)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Monitor: compare outputs with the head of the scoreboard.
  task automatic observe(input string tag);
    check(tag, "avail", int'(avail), int'(sb.size() != 0));
    check(tag, "full", int'(full), int'(sb.size() == DEPTH));
    if (sb.size() != 0) check(tag, "pop_data", int'(pop_data), int'(sb[0]));
  endtask

  // Driver: one cycle of stimulus; accepted items go into / out of the scoreboard.
  task automatic cycle(input string tag, input bit p, input logic [DATA_W-1:0] d, input bit r);
    bit rd_ok, wr_ok;
    @(negedge clk);
    observe(tag);
    push = p; push_data = d; pop = r;
    rd_ok = r && (sb.size() != 0);
    wr_ok = p && ((sb.size() < DEPTH) || rd_ok);
    @(posedge clk);
    if (rd_ok) void'(sb.pop_front());
    if (wr_ok) sb.push_back(d);
    @(negedge clk);
    push = 1'b0; pop = 1'b0;
    observe(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    srst = 1'b1;
    @(posedge clk);
    sb.delete();
    @(negedge clk);
    srst = 1'b0;
    observe("R1");
  endtask

  initial begin
    repeat (2) @(posedge clk);
    do_reset();                                  // R1 reset state
    cycle("R5", 1'b0, 8'h00, 1'b1);              // R5 pop on empty
    cycle("R2", 1'b1, 8'hA1, 1'b0);              // R2 falls through
    check("R2", "head", int'(pop_data), 'hA1);
    cycle("R3", 1'b0, 8'h00, 1'b0);              // R3 head held
    for (int i = 1; i < DEPTH; i++) cycle("R9", 1'b1, 8'(8'h10 + i), 1'b0);
    check("R9", "full", int'(full), 1);
    cycle("R6", 1'b1, 8'hEE, 1'b0);              // R6 refused write
    cycle("R7", 1'b1, 8'h77, 1'b1);              // R7 swap at full
    check("R7", "full", int'(full), 1);
    cycle("R10", 1'b0, 8'h00, 1'b1);
    cycle("R10", 1'b1, 8'h55, 1'b1);             // R10 swap partly full
    for (int i = 0; i < DEPTH + 1; i++) cycle("R4", 1'b0, 8'h00, 1'b1); // R3 R4 drain
    check("R4", "avail", int'(avail), 0);
    cycle("R8", 1'b1, 8'hC3, 1'b1);              // R8 push+pop on empty
    check("R8", "head", int'(pop_data), 'hC3);
    for (int i = 0; i < 40; i++)
      cycle("R4", (i % 3) != 2, 8'(i * 7 + 3), (i % 4) == 1 || i > 30);
    cycle("R2", 1'b1, 8'h9D, 1'b0);
    do_reset();                                  // R1 reset discards data
    cycle("R1", 1'b1, 8'h42, 1'b0);
    check("R1", "head after reset", int'(pop_data), 'h42);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule